// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 SDRAM from power-on to normal operation. A single-cycle start pulse captures the base address and the geometry settings: column code, row code, interleaved-decode flag and 16-bit bus flag. The block then issues a fixed chain of memory commands. Each command is presented as a strobe with a 3-bit code and a target address, and it is held until the command path acknowledges it. A programmable wait follows the first NOP. Around the mode-register cycles the block drives two live configuration flags, DLL reset and OCD default. At the end it pulses a refresh-rate load and then done.

The extended mode-register cycles must reach a particular bank. The block therefore computes the bit position of the bank-select field from the captured geometry. It places the selector value for EMRS2, EMRS3 or EMRS1 at that position above the base address.

States:
- `ST_IDLE` goes to `ST_NOP_A` on start.
- `ST_NOP_A`, `ST_NOP_B`, `ST_PALL_A`, `ST_EMR2`, `ST_EMR3`, `ST_EMR1_A`, `ST_MRS_A`, `ST_PALL_B`, `ST_REF_A`, `ST_REF_B`, `ST_MRS_B`, `ST_EMR1_OCD`, `ST_EMR1_EXIT`, `ST_NORMAL` and `ST_DUMMY` are command states. Each one advances to the next in that order on acknowledge, except `ST_NOP_A`, which goes to `ST_WAIT`.
- `ST_WAIT` goes to `ST_NOP_B` when the down-counter reaches zero.
- `ST_DUMMY` goes to `ST_RTR` on acknowledge.
- `ST_RTR` goes to `ST_DONE`, and `ST_DONE` goes to `ST_IDLE`, each after one cycle.

Top module: `ddr2_init_seq`

## Requirements
- R1: After a synchronous active-high reset, cmd_valid_o, rtr_load_o, done_o and dll_rst_o are 0 and ocd_dflt_o is 3'b000. This holds until a start pulse.
- R2: Fifteen strobes are issued in this order, with code values 0 normal, 1 NOP, 2 precharge-all, 3 load mode, 4 auto-refresh and 5 extended load mode: 1,1,2,5,5,5,3,2,4,4,3,5,5,0,0. The last code-0 strobe is the dummy write.
- R3: While cmd_valid_o is 1 and cmd_ack_i is 0, the strobe stays high and cmd_code_o and cmd_addr_o stay unchanged in the next cycle.
- R4: Between the acknowledge of the first NOP and the second NOP strobe, cmd_valid_o is low for exactly wait_cnt_i+1 cycles. A wait count of 0 gives one cycle.
- R5: The bank offset is col_code+9, plus row_code+11 when interleave_i is 0, plus 1 when bus16_i is 1 or 2 when bus16_i is 0.
- R6: The 4th, 5th and 6th strobes and the 12th and 13th strobes target base + (sel << offset), with sel = 2, 3, 1, 1, 1 respectively. Every other strobe targets the base address.
- R7: With interleave_i = 1 the row code has no effect on the offset.
- R8: dll_rst_o is 1 during the first load-mode strobe, the second precharge-all strobe and both refresh strobes. It is 0 at every other strobe, including the second load-mode strobe.
- R9: ocd_dflt_o equals 3'b111 only during the 12th strobe (the first EMRS1 after the second load-mode strobe). It is 3'b000 at all other strobes.
- R10: rtr_load_o is high for one cycle, the cycle right after the dummy write is acknowledged. done_o is high for one cycle, the cycle after that.
- R11: A start pulse during a running sequence is ignored. Base address and geometry are taken only at the start pulse that leaves idle.
- R12: Reset during a sequence returns the block to idle with no strobe and both flags cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only in idle |
| col_code_i | input | 2 | Column count code (0..3 = 9..12 columns) |
| row_code_i | input | 2 | Row count code (0..3 = 11..14 rows) |
| interleave_i | input | 1 | Interleaved bank decode selected |
| bus16_i | input | 1 | 1 = 16-bit data bus, 0 = 32-bit |
| base_addr_i | input | AW | Base address of the memory |
| wait_cnt_i | input | WW | Power-up wait length in cycles, minus one |
| cmd_ack_i | input | 1 | Command accepted |
| cmd_valid_o | output | 1 | Command strobe |
| cmd_code_o | output | 3 | Command code |
| cmd_addr_o | output | AW | Command target address |
| dll_rst_o | output | 1 | DLL-reset configuration flag |
| ocd_dflt_o | output | 3 | OCD-default configuration field |
| rtr_load_o | output | 1 | Refresh-rate load pulse |
| done_o | output | 1 | Sequence finished pulse |

## Verification
The sequence runs with four geometries:
- Minimum column and row codes on a 16-bit bus give offset 21.
- Maximum codes on a 32-bit bus give offset 28, the top of the range.
- Interleaved decode with the highest row code shows that the row term drops out.
- A repeat of the interleaved run with a different row code must give identical addresses.

Acknowledge latencies of 0, 1 and 2 cycles separate correct holding from early advancing. Wait counts of 0, 3 and 5 expose off-by-one errors in the down-counter. A mid-run start pulse with changed inputs shows whether the captured values are protected, and a reset placed while the DLL flag is high shows whether the flags are cleared.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    typedef enum logic [2:0] {
        CMD_NORMAL = 3'd0,
        CMD_NOP    = 3'd1,
        CMD_PALL   = 3'd2,
        CMD_MRS    = 3'd3,
        CMD_REF    = 3'd4,
        CMD_EMRS   = 3'd5,
        CMD_DPD    = 3'd6,
        CMD_LP2    = 3'd7
    } ddr_cmd_e;

    typedef enum logic [4:0] {
        ST_IDLE, ST_NOP_A, ST_WAIT, ST_NOP_B, ST_PALL_A,
        ST_EMR2, ST_EMR3, ST_EMR1_A, ST_MRS_A, ST_PALL_B,
        ST_REF_A, ST_REF_B, ST_MRS_B, ST_EMR1_OCD, ST_EMR1_EXIT,
        ST_NORMAL, ST_DUMMY, ST_RTR, ST_DONE
    } seq_st_e;

    localparam int OFS_W = 5;
    localparam logic [2:0] OCD_ON = 3'b111;

endpackage

// File: rtl/ddr2_bank_ofs.sv
module ddr2_bank_ofs
    import ddr2_init_pkg::*;
(
    input  logic [1:0]       col_code_i,
    input  logic [1:0]       row_code_i,
    input  logic             interleave_i,
    input  logic             bus16_i,
    output logic [OFS_W-1:0] ofs_o
);
    logic [OFS_W-1:0] col_term;
    logic [OFS_W-1:0] row_term;
    logic [OFS_W-1:0] bus_term;

    always_comb begin
        col_term = OFS_W'(col_code_i) + OFS_W'(9);
        row_term = interleave_i ? '0 : (OFS_W'(row_code_i) + OFS_W'(11));
        bus_term = bus16_i ? OFS_W'(1) : OFS_W'(2);
        ofs_o    = col_term + row_term + bus_term;
    end
endmodule

// File: rtl/ddr2_wait_timer.sv
module ddr2_wait_timer #(
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [WW-1:0] load_val_i,
    input  logic          run_i,
    output logic          expired_o
);
    logic [WW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (run_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int AW = 32,
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [1:0]    col_code_i,
    input  logic [1:0]    row_code_i,
    input  logic          interleave_i,
    input  logic          bus16_i,
    input  logic [AW-1:0] base_addr_i,
    input  logic [WW-1:0] wait_cnt_i,
    input  logic          cmd_ack_i,
    output logic          cmd_valid_o,
    output logic [2:0]    cmd_code_o,
    output logic [AW-1:0] cmd_addr_o,
    output logic          dll_rst_o,
    output logic [2:0]    ocd_dflt_o,
    output logic          rtr_load_o,
    output logic          done_o
);
    localparam int SEL_PAD = AW - 2;

    seq_st_e          state, state_nx;
    logic [AW-1:0]    base_q;
    logic [OFS_W-1:0] ofs_q, ofs_calc;
    logic             dll_q;
    logic [2:0]       ocd_q;
    logic             wait_done;
    logic [1:0]       bank_sel;
    logic             fire;

    ddr2_bank_ofs u_ofs (
        .col_code_i   (col_code_i),
        .row_code_i   (row_code_i),
        .interleave_i (interleave_i),
        .bus16_i      (bus16_i),
        .ofs_o        (ofs_calc)
    );

    ddr2_wait_timer #(.WW(WW)) u_wait (
        .clk        (clk),
        .rst        (rst),
        .load_i     (state == ST_NOP_A && cmd_ack_i),
        .load_val_i (wait_cnt_i),
        .run_i      (state == ST_WAIT),
        .expired_o  (wait_done)
    );

    assign fire = cmd_valid_o && cmd_ack_i;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // captured settings and configuration flags
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            ofs_q  <= '0;
            dll_q  <= 1'b0;
            ocd_q  <= 3'b000;
        end else begin
            if (state == ST_IDLE && start_i) begin
                base_q <= base_addr_i;
                ofs_q  <= ofs_calc;
            end
            if (fire) begin
                unique case (state)
                    ST_EMR1_A:   dll_q <= 1'b1;
                    ST_REF_B:    dll_q <= 1'b0;
                    ST_MRS_B:    ocd_q <= OCD_ON;
                    ST_EMR1_OCD: ocd_q <= 3'b000;
                    default: ;
                endcase
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start_i)   state_nx = ST_NOP_A;
            ST_NOP_A:     if (cmd_ack_i) state_nx = ST_WAIT;
            ST_WAIT:      if (wait_done) state_nx = ST_NOP_B;
            ST_NOP_B:     if (cmd_ack_i) state_nx = ST_PALL_A;
            ST_PALL_A:    if (cmd_ack_i) state_nx = ST_EMR2;
            ST_EMR2:      if (cmd_ack_i) state_nx = ST_EMR3;
            ST_EMR3:      if (cmd_ack_i) state_nx = ST_EMR1_A;
            ST_EMR1_A:    if (cmd_ack_i) state_nx = ST_MRS_A;
            ST_MRS_A:     if (cmd_ack_i) state_nx = ST_PALL_B;
            ST_PALL_B:    if (cmd_ack_i) state_nx = ST_REF_A;
            ST_REF_A:     if (cmd_ack_i) state_nx = ST_REF_B;
            ST_REF_B:     if (cmd_ack_i) state_nx = ST_MRS_B;
            ST_MRS_B:     if (cmd_ack_i) state_nx = ST_EMR1_OCD;
            ST_EMR1_OCD:  if (cmd_ack_i) state_nx = ST_EMR1_EXIT;
            ST_EMR1_EXIT: if (cmd_ack_i) state_nx = ST_NORMAL;
            ST_NORMAL:    if (cmd_ack_i) state_nx = ST_DUMMY;
            ST_DUMMY:     if (cmd_ack_i) state_nx = ST_RTR;
            ST_RTR:       state_nx = ST_DONE;
            ST_DONE:      state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_valid_o = 1'b1;
        cmd_code_o  = CMD_NORMAL;
        bank_sel    = 2'd0;
        rtr_load_o  = 1'b0;
        done_o      = 1'b0;
        unique case (state)
            ST_IDLE, ST_WAIT:       cmd_valid_o = 1'b0;
            ST_NOP_A, ST_NOP_B:     cmd_code_o  = CMD_NOP;
            ST_PALL_A, ST_PALL_B:   cmd_code_o  = CMD_PALL;
            ST_EMR2: begin
                cmd_code_o = CMD_EMRS;
                bank_sel   = 2'd2;
            end
            ST_EMR3: begin
                cmd_code_o = CMD_EMRS;
                bank_sel   = 2'd3;
            end
            ST_EMR1_A, ST_EMR1_OCD, ST_EMR1_EXIT: begin
                cmd_code_o = CMD_EMRS;
                bank_sel   = 2'd1;
            end
            ST_MRS_A, ST_MRS_B:     cmd_code_o  = CMD_MRS;
            ST_REF_A, ST_REF_B:     cmd_code_o  = CMD_REF;
            ST_NORMAL, ST_DUMMY:    cmd_code_o  = CMD_NORMAL;
            ST_RTR: begin
                cmd_valid_o = 1'b0;
                rtr_load_o  = 1'b1;
            end
            ST_DONE: begin
                cmd_valid_o = 1'b0;
                done_o      = 1'b1;
            end
            default: cmd_valid_o = 1'b0;
        endcase
        cmd_addr_o = base_q + ({{SEL_PAD{1'b0}}, bank_sel} << ofs_q);
    end

    assign dll_rst_o  = dll_q;
    assign ocd_dflt_o = ocd_q;

    // R3: command held until accepted
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o && !cmd_ack_i |=> cmd_valid_o && $stable(cmd_code_o) && $stable(cmd_addr_o));

    // R10: done follows the refresh-rate load pulse
    p_done_after_rtr_r10: assert property (@(posedge clk) disable iff (rst)
        rtr_load_o |=> done_o && !rtr_load_o);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9: OCD default only while an extended mode cycle is presented
    p_ocd_on_emrs_r9: assert property (@(posedge clk) disable iff (rst)
        (ocd_dflt_o != 3'b000) |-> cmd_valid_o && cmd_code_o == CMD_EMRS);

    // R8: DLL reset never overlaps OCD default
    p_dll_no_ocd_r8: assert property (@(posedge clk) disable iff (rst)
        dll_rst_o |-> ocd_dflt_o == 3'b000);

    // R1: no strobe while idle-equivalent outputs pulse
    p_quiet_ends_r1: assert property (@(posedge clk) disable iff (rst)
        (rtr_load_o || done_o) |-> !cmd_valid_o);

endmodule

// File: tb/ddr2_init_seq_tb.sv
module ddr2_init_seq_tb;
    localparam int AW = 32;
    localparam int WW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          start_i;
    logic [1:0]    col_code_i, row_code_i;
    logic          interleave_i, bus16_i;
    logic [AW-1:0] base_addr_i;
    logic [WW-1:0] wait_cnt_i;
    logic          cmd_ack_i;
    logic          cmd_valid_o;
    logic [2:0]    cmd_code_o;
    logic [AW-1:0] cmd_addr_o;
    logic          dll_rst_o;
    logic [2:0]    ocd_dflt_o;
    logic          rtr_load_o, done_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    ddr2_init_seq #(.AW(AW), .WW(WW)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .col_code_i(col_code_i), .row_code_i(row_code_i),
        .interleave_i(interleave_i), .bus16_i(bus16_i),
        .base_addr_i(base_addr_i), .wait_cnt_i(wait_cnt_i),
        .cmd_ack_i(cmd_ack_i), .cmd_valid_o(cmd_valid_o),
        .cmd_code_o(cmd_code_o), .cmd_addr_o(cmd_addr_o),
        .dll_rst_o(dll_rst_o), .ocd_dflt_o(ocd_dflt_o),
        .rtr_load_o(rtr_load_o), .done_o(done_o)
    );

    always #5 clk = ~clk;

    localparam logic [2:0] EXP_CODE [15] = '{3'd1,3'd1,3'd2,3'd5,3'd5,3'd5,3'd3,3'd2,
                                              3'd4,3'd4,3'd3,3'd5,3'd5,3'd0,3'd0};
    localparam logic [1:0] EXP_SEL  [15] = '{2'd0,2'd0,2'd0,2'd2,2'd3,2'd1,2'd0,2'd0,
                                              2'd0,2'd0,2'd0,2'd1,2'd1,2'd0,2'd0};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_ofs(input logic [1:0] col, input logic [1:0] row,
                                   input logic il, input logic b16);
        int o;
        o = int'(col) + 9;
        if (!il) o = o + int'(row) + 11;
        o = o + (b16 ? 1 : 2);
        return o;
    endfunction

    task automatic do_reset();
        rst = 1'b1; start_i = 1'b0; cmd_ack_i = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Runs one sequence acting as the command acceptor.
    task automatic run_seq(input logic [1:0] col, input logic [1:0] row,
                           input logic il, input logic b16,
                           input logic [AW-1:0] base, input logic [WW-1:0] w,
                           input int ackd, input bit inject, input int abort_at,
                           input string tag);
        int ofs;
        logic [AW-1:0] exp_addr;
        logic [2:0]    rc;
        logic [AW-1:0] ra;
        bit            held;
        ofs = exp_ofs(col, row, il, b16);
        @(negedge clk);
        col_code_i = col; row_code_i = row; interleave_i = il; bus16_i = b16;
        base_addr_i = base; wait_cnt_i = w; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int idx = 0; idx < 15; idx++) begin
            int lows = 0;
            while (!cmd_valid_o && lows < 70000) begin
                @(negedge clk);
                lows++;
            end
            if (idx == 1)
                chk(lows == int'(w) + 1, "R4", {tag, " wait low cycles"}, 64'(lows), 64'(int'(w) + 1));
            rc = cmd_code_o; ra = cmd_addr_o;
            exp_addr = base + (AW'(EXP_SEL[idx]) << ofs);
            chk(cmd_valid_o && rc == EXP_CODE[idx], "R2", $sformatf("%s code idx %0d", tag, idx),
                64'(rc), 64'(EXP_CODE[idx]));
            chk(ra == exp_addr, (EXP_SEL[idx] != 0) ? "R6" : "R5",
                $sformatf("%s addr idx %0d", tag, idx), 64'(ra), 64'(exp_addr));
            chk(dll_rst_o == (idx >= 6 && idx <= 9), "R8", $sformatf("%s dll idx %0d", tag, idx),
                64'(dll_rst_o), 64'(idx >= 6 && idx <= 9));
            chk(ocd_dflt_o == ((idx == 11) ? 3'b111 : 3'b000), "R9",
                $sformatf("%s ocd idx %0d", tag, idx), 64'(ocd_dflt_o), 64'((idx == 11) ? 7 : 0));
            if (idx == abort_at) begin
                rst = 1'b1;
                @(negedge clk);
                rst = 1'b0;
                for (int k = 0; k < 4; k++) begin
                    chk(!cmd_valid_o && !dll_rst_o && ocd_dflt_o == 3'b000 && !done_o,
                        "R12", $sformatf("%s idle after reset %0d", tag, k),
                        64'({cmd_valid_o, dll_rst_o, ocd_dflt_o, done_o}), 64'(0));
                    @(negedge clk);
                end
                return;
            end
            held = 1'b1;
            for (int d = 0; d < ackd; d++) begin
                @(negedge clk);
                if (!(cmd_valid_o && cmd_code_o == rc && cmd_addr_o == ra)) held = 1'b0;
            end
            if (inject && idx == 3) begin
                start_i = 1'b1; base_addr_i = ~base; col_code_i = ~col;
                interleave_i = ~il; bus16_i = ~b16;
                @(negedge clk);
                start_i = 1'b0;
                if (!(cmd_valid_o && cmd_code_o == rc && cmd_addr_o == ra)) held = 1'b0;
            end
            if (ackd > 0 || inject)
                chk(held, inject ? "R11" : "R3", $sformatf("%s hold idx %0d", tag, idx),
                    64'(cmd_addr_o), 64'(ra));
            cmd_ack_i = 1'b1;
            @(negedge clk);
            cmd_ack_i = 1'b0;
        end
        chk(rtr_load_o && !done_o && !cmd_valid_o, "R10", {tag, " rtr pulse"},
            64'({rtr_load_o, done_o}), 64'(2));
        @(negedge clk);
        chk(!rtr_load_o && done_o, "R10", {tag, " done pulse"}, 64'({rtr_load_o, done_o}), 64'(1));
        @(negedge clk);
        chk(!done_o && !cmd_valid_o, "R10", {tag, " back to idle"}, 64'({done_o, cmd_valid_o}), 64'(0));
    endtask

    task automatic test_reset_state();
        do_reset();
        for (int k = 0; k < 3; k++) begin
            chk(!cmd_valid_o && !rtr_load_o && !done_o && !dll_rst_o && ocd_dflt_o == 3'b000,
                "R1", "reset state", 64'({cmd_valid_o, rtr_load_o, done_o, dll_rst_o, ocd_dflt_o}), 64'(0));
            @(negedge clk);
        end
    endtask

    task automatic test_narrow_geometry();
        run_seq(2'd0, 2'd0, 1'b0, 1'b1, 32'h2000_0000, 16'd5, 0, 1'b0, -1, "R5 min-geom");
    endtask

    task automatic test_wide_geometry();
        run_seq(2'd3, 2'd3, 1'b0, 1'b0, 32'h2000_0000, 16'd0, 2, 1'b0, -1, "R5 max-geom");
    endtask

    task automatic test_interleaved();
        run_seq(2'd2, 2'd3, 1'b1, 1'b1, 32'h7000_0000, 16'd3, 1, 1'b0, -1, "R7 interleave-row3");
        run_seq(2'd2, 2'd0, 1'b1, 1'b1, 32'h7000_0000, 16'd3, 0, 1'b0, -1, "R7 interleave-row0");
    endtask

    task automatic test_start_ignored();
        run_seq(2'd1, 2'd2, 1'b0, 1'b1, 32'h0010_0000, 16'd2, 1, 1'b1, -1, "R11 mid-start");
    endtask

    task automatic test_mid_reset();
        run_seq(2'd1, 2'd1, 1'b0, 1'b0, 32'h0000_0000, 16'd1, 0, 1'b0, 7, "R12 abort");
        run_seq(2'd1, 2'd1, 1'b0, 1'b0, 32'h0000_0000, 16'd1, 0, 1'b0, -1, "R12 rerun");
    endtask

    initial begin
        rst = 1'b1; start_i = 1'b0; cmd_ack_i = 1'b0;
        col_code_i = '0; row_code_i = '0; interleave_i = 1'b0; bus16_i = 1'b0;
        base_addr_i = '0; wait_cnt_i = '0;
        test_reset_state();
        test_narrow_geometry();
        test_wide_geometry();
        test_interleaved();
        test_start_ignored();
        test_mid_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule